// File: doc/BRIEF.md
# Keyboard Serial Receive Controller

This block listens to a two-wire synchronous keyboard link: a clock line and a data line, both driven by the keyboard. Each line passes through a synchronizer. On every falling edge of the synchronized clock the block samples the data line and assembles a frame. A frame that passes its checks places its byte in a read-only buffer register.

A small register port exposes an 8-bit control/status byte at address 0 and the buffer at address 1. The control byte holds these fields:

- an enable that hands both lines to the controller;
- live readback of both pins;
- a mode select for the shared status flag;
- an interrupt enable;
- the shared flag, which means "buffer full" or "clock edge seen" depending on the mode;
- a parity-error flag;
- the stop bit of the last frame.

The interrupt output is the AND of the interrupt enable and the shared flag. Software clears a flag in two steps. It first reads the flag while the flag is 1, then writes a 0 to it.

Top module: `kbd_rx_ctrl`

## Requirements
- R1: After reset the control byte (address 0) reads 0x60 with both lines idle high, the buffer (address 1) reads 0x00, and `irq` and `lines_owned` are 0.
- R2: Bit 7 is a read/write enable, mirrored on `lines_owned`. While bit 7 is 0, falling clock edges have no effect on any flag or on reception. Clearing bit 7 returns the receiver to waiting for a start bit.
- R3: Bit 6 reads the clock line level and bit 5 reads the data line level, each two clock cycles after the pin changes (two-flop synchronizer).
- R4: A frame is a start bit of 0, then 8 data bits with the least significant bit first, then an odd-parity bit, then a stop bit. Each bit is sampled on a falling clock edge. A 1 seen where a start bit is expected is ignored.
- R5: With bit 4 = 1 (buffer mode), a frame with correct parity and a stop bit of 1 writes its byte to the buffer and sets bit 2. A frame with a stop bit of 0 changes neither the buffer nor bit 2.
- R6: With bit 4 = 0 (edge mode), every enabled falling clock edge sets bit 2.
- R7: Bit 1 is set when the data bits and the parity bit together hold an even number of ones. Such a frame leaves the buffer unchanged and does not set bit 2.
- R8: Bit 0 is read-only and takes the stop-bit value of every complete frame.
- R9: `irq` equals bit 3 AND bit 2.
- R10: A write to address 0 with bit 2 (or bit 1) = 0 clears that flag only if a read of address 0 returned the flag as 1 since it was last set. A write of 1 to either flag has no effect. Writes to bits 6, 5 and 0 and to address 1 are ignored.
- R11: When a flag is set in the same cycle as a qualifying clearing write, the flag stays 1, and a further read is needed before a later write can clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_clk_i | input | 1 | Keyboard clock line level |
| kbd_dat_i | input | 1 | Keyboard data line level |
| reg_addr | input | 1 | 0 selects the control byte, 1 the buffer |
| reg_rd | input | 1 | Read strobe (arms flag clearing) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected address |
| irq | output | 1 | Interrupt request |
| lines_owned | output | 1 | High while the controller owns both lines |

## Verification
Two events can land in the same cycle: the shared flag being set by a clock falling edge, and a software write that would clear that flag. The bench first arms the clear with a read. It then drops the keyboard clock and schedules the write two cycles later, so the write and the edge-mode set reach the flag on the same clock edge. It judges the result by checking that the flag and `irq` remain 1, and that a later write without a fresh read still leaves the flag set.

// File: rtl/kbd_rx_pkg.sv
package kbd_rx_pkg;

    localparam int KBD_REG_W = 8;

    // Control byte field positions (software decodes these)
    localparam int B_EN   = 7;
    localparam int B_PCLK = 6;
    localparam int B_PDAT = 5;
    localparam int B_FSEL = 4;
    localparam int B_IE   = 3;
    localparam int B_FLAG = 2;
    localparam int B_PERR = 1;
    localparam int B_STOP = 0;

    typedef enum logic [0:0] {
        ADDR_CTRL = 1'b0,
        ADDR_BUF  = 1'b1
    } kbd_addr_e;

endpackage

// File: rtl/kbd_pin_sync.sv
module kbd_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_in,
    input  logic dat_in,
    output logic clk_lvl,
    output logic dat_lvl,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] c_sh;
        logic [STAGES-1:0] d_sh;
        logic              c_last;
    } st_t;

    st_t q, d;

    always_comb begin
        d        = q;
        d.c_sh   = {q.c_sh[STAGES-2:0], clk_in};
        d.d_sh   = {q.d_sh[STAGES-2:0], dat_in};
        d.c_last = q.c_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.c_sh   <= '1;
            q.d_sh   <= '1;
            q.c_last <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign clk_lvl = q.c_sh[STAGES-1];
    assign dat_lvl = q.d_sh[STAGES-1];
    assign fall    = q.c_last & ~q.c_sh[STAGES-1];

endmodule

// File: rtl/kbd_frame_rx.sv
module kbd_frame_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              fall,
    input  logic              dat,
    output logic              idle,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              stop
);

    localparam int CNT_W = $clog2(DATA_W + 3);
    localparam logic [CNT_W-1:0] DATA_END = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] PAR_POS  = CNT_W'(DATA_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic              par;
        logic              done;
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              stop;
    } st_t;

    st_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!en) begin
            d.cnt = '0;
        end else if (fall) begin
            if (q.cnt == '0) begin
                if (!dat) d.cnt = CNT_W'(1);
            end else if (q.cnt <= DATA_END) begin
                d.sh  = {dat, q.sh[DATA_W-1:1]};
                d.cnt = q.cnt + 1'b1;
            end else if (q.cnt == PAR_POS) begin
                d.par = dat;
                d.cnt = q.cnt + 1'b1;
            end else begin
                d.done = 1'b1;
                d.data = q.sh;
                d.perr = ~(^{q.sh, q.par});
                d.stop = dat;
                d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign idle = (q.cnt == '0);
    assign done = q.done;
    assign data = q.data;
    assign perr = q.perr;
    assign stop = q.stop;

endmodule

// File: rtl/kbd_csr.sv
module kbd_csr
    import kbd_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pin_clk,
    input  logic                 pin_dat,
    input  logic                 fall,
    input  logic                 frm_done,
    input  logic [DATA_W-1:0]    frm_data,
    input  logic                 frm_perr,
    input  logic                 frm_stop,
    input  logic                 addr,
    input  logic                 rd,
    input  logic                 wr,
    input  logic [KBD_REG_W-1:0] wdata,
    output logic [KBD_REG_W-1:0] rdata,
    output logic [KBD_REG_W-1:0] ctrl,
    output logic [DATA_W-1:0]    buf_v,
    output logic                 en,
    output logic                 fsel,
    output logic                 irq
);

    typedef struct packed {
        logic              en;
        logic              fsel;
        logic              ie;
        logic              flag;
        logic              perr;
        logic              stop;
        logic              arm_f;
        logic              arm_p;
        logic [DATA_W-1:0] bufr;
    } st_t;

    st_t  q, d;
    logic ctrl_sel;
    logic set_flag;
    logic unused_wbits;

    assign ctrl_sel     = (addr == ADDR_CTRL);
    assign unused_wbits = ^{wdata[B_PCLK], wdata[B_PDAT], wdata[B_STOP]};
    assign set_flag     = q.fsel ? (frm_done & ~frm_perr & frm_stop)
                                 : (fall & q.en);

    always_comb begin
        d = q;
        // a read that returns a flag as 1 arms its clearing
        if (rd && ctrl_sel) begin
            if (q.flag) d.arm_f = 1'b1;
            if (q.perr) d.arm_p = 1'b1;
        end
        if (wr && ctrl_sel) begin
            d.en   = wdata[B_EN];
            d.fsel = wdata[B_FSEL];
            d.ie   = wdata[B_IE];
            if (!wdata[B_FLAG] && q.arm_f) begin
                d.flag  = 1'b0;
                d.arm_f = 1'b0;
            end
            if (!wdata[B_PERR] && q.arm_p) begin
                d.perr  = 1'b0;
                d.arm_p = 1'b0;
            end
        end
        // hardware set has priority over a software clear
        if (set_flag) begin
            d.flag  = 1'b1;
            d.arm_f = 1'b0;
        end
        if (frm_done) begin
            d.stop = frm_stop;
            if (frm_perr) begin
                d.perr  = 1'b1;
                d.arm_p = 1'b0;
            end else if (frm_stop) begin
                d.bufr = frm_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        ctrl         = '0;
        ctrl[B_EN]   = q.en;
        ctrl[B_PCLK] = pin_clk;
        ctrl[B_PDAT] = pin_dat;
        ctrl[B_FSEL] = q.fsel;
        ctrl[B_IE]   = q.ie;
        ctrl[B_FLAG] = q.flag;
        ctrl[B_PERR] = q.perr;
        ctrl[B_STOP] = q.stop;
    end

    assign rdata = ctrl_sel ? ctrl : KBD_REG_W'(q.bufr);
    assign buf_v = q.bufr;
    assign en    = q.en;
    assign fsel  = q.fsel;
    assign irq   = q.ie & q.flag;

endmodule

// File: rtl/kbd_rx_ctrl.sv
module kbd_rx_ctrl
    import kbd_rx_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 kbd_clk_i,
    input  logic                 kbd_dat_i,
    input  logic                 reg_addr,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [KBD_REG_W-1:0] reg_wdata,
    output logic [KBD_REG_W-1:0] reg_rdata,
    output logic                 irq,
    output logic                 lines_owned
);

    logic              clk_lvl, dat_lvl, fall;
    logic              en, fsel, rx_idle;
    logic              frm_done, frm_perr, frm_stop;
    logic [DATA_W-1:0] frm_data;
    logic [DATA_W-1:0] buf_v;
    logic [KBD_REG_W-1:0] ctrl_v;

    kbd_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .clk_in  (kbd_clk_i),
        .dat_in  (kbd_dat_i),
        .clk_lvl (clk_lvl),
        .dat_lvl (dat_lvl),
        .fall    (fall)
    );

    kbd_frame_rx #(.DATA_W(DATA_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .fall  (fall),
        .dat   (dat_lvl),
        .idle  (rx_idle),
        .done  (frm_done),
        .data  (frm_data),
        .perr  (frm_perr),
        .stop  (frm_stop)
    );

    kbd_csr #(.DATA_W(DATA_W)) u_csr (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_clk  (clk_lvl),
        .pin_dat  (dat_lvl),
        .fall     (fall),
        .frm_done (frm_done),
        .frm_data (frm_data),
        .frm_perr (frm_perr),
        .frm_stop (frm_stop),
        .addr     (reg_addr),
        .rd       (reg_rd),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctrl     (ctrl_v),
        .buf_v    (buf_v),
        .en       (en),
        .fsel     (fsel),
        .irq      (irq)
    );

    assign lines_owned = en;

endmodule

// File: rtl/kbd_rx_ctrl_chk.sv
module kbd_rx_ctrl_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_addr,
    input logic              reg_wr,
    input logic [7:0]        reg_wdata,
    input logic [7:0]        reg_rdata,
    input logic              irq,
    input logic              en,
    input logic              fsel,
    input logic              rx_idle,
    input logic              frm_done,
    input logic              frm_perr,
    input logic              frm_stop,
    input logic [7:0]        ctrl_v,
    input logic [DATA_W-1:0] buf_v
);

    // R9
    irq_follows_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 1'b0) |-> (irq == (reg_rdata[3] & reg_rdata[2])));

    // R2
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> rx_idle);

    // R7
    perr_keeps_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && frm_perr) |=> $stable(buf_v));

    // R5
    full_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_done && !frm_perr && frm_stop && fsel) |=> ctrl_v[2]);

    // R10
    clear_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_v[2]) |-> $past(reg_wr && !reg_addr && !reg_wdata[2]));

    // R8
    stop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> (ctrl_v[0] == $past(frm_stop)));

endmodule

bind kbd_rx_ctrl kbd_rx_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq       (irq),
    .en        (en),
    .fsel      (fsel),
    .rx_idle   (rx_idle),
    .frm_done  (frm_done),
    .frm_perr  (frm_perr),
    .frm_stop  (frm_stop),
    .ctrl_v    (ctrl_v),
    .buf_v     (buf_v)
);

// File: tb/sim_kbd_rx_ctrl.sv
module sim_kbd_rx_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kclk = 1'b1, kdat = 1'b1;
    logic       reg_addr = 1'b0, reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, lines_owned;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    kbd_rx_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .kbd_clk_i(kclk), .kbd_dat_i(kdat),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .lines_owned(lines_owned)
    );

    // ---------------- behavioural reference model ----------------
    bit m_p1c, m_visc, m_lastc, m_p1d, m_visd;
    bit m_en, m_fsel, m_ie, m_flag, m_perr, m_stop, m_af, m_ap;
    bit [7:0] m_buf;
    int  m_phase;
    bit [7:0] m_byte;
    bit  m_par;
    bit  m_dn, m_dperr, m_dstop;
    bit [7:0] m_dbyte;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_p1c = 1; m_visc = 1; m_lastc = 1; m_p1d = 1; m_visd = 1;
            m_en = 0; m_fsel = 0; m_ie = 0; m_flag = 0; m_perr = 0; m_stop = 0;
            m_af = 0; m_ap = 0; m_buf = 0; m_phase = 0; m_byte = 0; m_par = 0;
            m_dn = 0; m_dperr = 0; m_dstop = 0; m_dbyte = 0;
        end else begin
            bit fall, dbit, n_dn;
            bit n_en, n_fsel, n_ie, n_flag, n_perr, n_stop, n_af, n_ap;
            bit [7:0] n_buf;
            fall = m_lastc && !m_visc;
            dbit = m_visd;
            n_en = m_en; n_fsel = m_fsel; n_ie = m_ie; n_flag = m_flag;
            n_perr = m_perr; n_stop = m_stop; n_af = m_af; n_ap = m_ap; n_buf = m_buf;
            if (reg_rd && !reg_addr) begin
                if (m_flag) n_af = 1;
                if (m_perr) n_ap = 1;
            end
            if (reg_wr && !reg_addr) begin
                n_en = reg_wdata[7]; n_fsel = reg_wdata[4]; n_ie = reg_wdata[3];
                if (!reg_wdata[2] && m_af) begin n_flag = 0; n_af = 0; end
                if (!reg_wdata[1] && m_ap) begin n_perr = 0; n_ap = 0; end
            end
            if (m_fsel ? (m_dn && !m_dperr && m_dstop) : (fall && m_en)) begin
                n_flag = 1; n_af = 0;
            end
            if (m_dn) begin
                n_stop = m_dstop;
                if (m_dperr) begin n_perr = 1; n_ap = 0; end
                else if (m_dstop) n_buf = m_dbyte;
            end
            n_dn = 0;
            if (!m_en) m_phase = 0;
            else if (fall) begin
                if (m_phase == 0) begin
                    if (!dbit) m_phase = 1;
                end else if (m_phase <= 8) begin
                    m_byte[m_phase-1] = dbit; m_phase++;
                end else if (m_phase == 9) begin
                    m_par = dbit; m_phase = 10;
                end else begin
                    n_dn = 1; m_dbyte = m_byte; m_dstop = dbit;
                    m_dperr = ((($countones(m_byte) + int'(m_par)) % 2) == 0);
                    m_phase = 0;
                end
            end
            m_dn = n_dn;
            m_en = n_en; m_fsel = n_fsel; m_ie = n_ie; m_flag = n_flag;
            m_perr = n_perr; m_stop = n_stop; m_af = n_af; m_ap = n_ap; m_buf = n_buf;
            m_lastc = m_visc; m_visc = m_p1c; m_p1c = kclk;
            m_visd = m_p1d; m_p1d = kdat;
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // every-cycle comparison, away from the active edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !finished) begin
            check("R9 irq", {7'b0, irq}, {7'b0, m_ie & m_flag});
            check("R2 lines_owned", {7'b0, lines_owned}, {7'b0, m_en});
            if (reg_addr) begin
                check("R5 buffer", reg_rdata, m_buf);
            end else begin
                check("R2 R10 writable bits", {reg_rdata[7], reg_rdata[4:3]},
                      {5'b0, m_en, m_fsel, m_ie});
                check("R3 pin readback", {6'b0, reg_rdata[6:5]}, {6'b0, m_visc, m_visd});
                check(m_fsel ? "R5 flag" : "R6 flag", {7'b0, reg_rdata[2]}, {7'b0, m_flag});
                check("R7 parity flag", {7'b0, reg_rdata[1]}, {7'b0, m_perr});
                check("R8 stop bit", {7'b0, reg_rdata[0]}, {7'b0, m_stop});
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_ctrl(logic [7:0] v);
        @(negedge clk); reg_addr = 0; reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic wr_buf(logic [7:0] v);
        @(negedge clk); reg_addr = 1; reg_wr = 1; reg_wdata = v;
        @(negedge clk); reg_wr = 0; reg_addr = 0;
    endtask

    task automatic rd_ctrl();
        @(negedge clk); reg_addr = 0; reg_rd = 1;
        @(negedge clk); reg_rd = 0;
    endtask

    task automatic peek(logic a, output logic [7:0] v);
        @(negedge clk); reg_addr = a;
        @(posedge clk); #3 v = reg_rdata;
        @(negedge clk); reg_addr = 0;
    endtask

    task automatic kbit(logic b);
        @(negedge clk); kdat = b;
        tick(3); kclk = 0;
        tick(5); kclk = 1;
        tick(5);
    endtask

    task automatic send(logic [7:0] v, logic bad_par, logic stop_v);
        kbit(1'b0);
        for (int i = 0; i < 8; i++) kbit(v[i]);
        kbit((~^v) ^ bad_par);
        kbit(stop_v);
        @(negedge clk); kdat = 1;
        tick(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        tick(4);
        rst_n = 1;
        tick(2);
        // R1 reset state
        peek(0, v); check("R1 ctrl after reset", v, 8'h60);
        peek(1, v); check("R1 buffer after reset", v, 8'h00);
        check("R1 irq after reset", {7'b0, irq}, 8'h00);

        // R4 R5 good frame in buffer mode
        wr_ctrl(8'h98);
        send(8'hA5, 0, 1);
        peek(1, v); check("R4 R5 byte received", v, 8'hA5);
        peek(0, v); check("R5 full flag set", v, 8'hFD);
        check("R9 irq raised", {7'b0, irq}, 8'h01);

        // R10 clear rules
        wr_ctrl(8'h98);
        peek(0, v); check("R10 unarmed write keeps flag", v, 8'hFD);
        rd_ctrl();
        wr_ctrl(8'h9C);
        peek(0, v); check("R10 write of 1 no effect", v, 8'hFD);
        wr_buf(8'h33);
        peek(1, v); check("R10 buffer write ignored", v, 8'hA5);
        wr_ctrl(8'h98);
        peek(0, v); check("R10 armed clear", v, 8'hF9);

        // R7 parity error
        wr_ctrl(8'h90);
        send(8'h3C, 1, 1);
        peek(0, v); check("R7 parity flag, no full", v, 8'hF3);
        peek(1, v); check("R7 buffer kept", v, 8'hA5);
        rd_ctrl();
        wr_ctrl(8'h90);
        peek(0, v); check("R7 parity flag cleared", v, 8'hF1);

        // R8 stop bit 0 frame
        send(8'h81, 0, 0);
        peek(0, v); check("R8 stop bit zero", v, 8'hF0);
        peek(1, v); check("R5 stop zero keeps buffer", v, 8'hA5);

        // R3 data line readback
        @(negedge clk); kdat = 0;
        tick(4);
        peek(0, v); check("R3 data low", v, 8'hD0);
        @(negedge clk); kdat = 1;
        tick(4);

        // R6 edge mode
        wr_ctrl(8'h88);
        @(negedge clk); kclk = 0;
        tick(5);
        peek(0, v); check("R6 R3 edge flag, clock low", v, 8'hAC);
        check("R9 irq edge mode", {7'b0, irq}, 8'h01);
        @(negedge clk); kclk = 1;
        tick(5);

        // R11 set and clear in the same cycle
        rd_ctrl();
        @(negedge clk); kclk = 0;
        @(negedge clk);
        @(negedge clk); reg_addr = 0; reg_wr = 1; reg_wdata = 8'h88;
        @(negedge clk); reg_wr = 0;
        tick(3);
        peek(0, v); check("R11 set wins", v, 8'hAC);
        @(negedge clk); kclk = 1;
        tick(5);
        wr_ctrl(8'h88);
        peek(0, v); check("R11 arm consumed", v, 8'hEC);

        // R2 disabled edges ignored
        rd_ctrl();
        wr_ctrl(8'h08);
        @(negedge clk); kclk = 0;
        tick(5);
        @(negedge clk); kclk = 1;
        tick(5);
        peek(0, v); check("R2 disabled edge ignored", v, 8'h68);
        check("R2 lines released", {7'b0, lines_owned}, 8'h00);

        // R2 abort mid-frame returns to idle; R4 stray high start ignored
        wr_ctrl(8'h98);
        kbit(1); kbit(0); kbit(1); kbit(0); kbit(1);
        wr_ctrl(8'h18);
        wr_ctrl(8'h98);
        send(8'h5A, 0, 1);
        peek(1, v); check("R2 R4 receive after abort", v, 8'h5A);
        peek(0, v); check("R5 full after abort", v, 8'hFD);

        tick(4);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule